// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Checker

This block computes a 16-bit check value over a block of 32-bit words, four bits at a time. Words are offered on a valid/ready handshake. Each word carries two flags. A start flag zeroes the running check value before that word is folded in. An end flag marks the last word of the block. The caller decides how many words the block holds by where it places the end flag.

Once a word is accepted, the block holds it internally and consumes it nibble by nibble, from the top nibble down. By default it handles one nibble per clock, so a word occupies the block for eight cycles, and ready stays low for that time. When the last word has been consumed, the check value appears on the result output together with a one-cycle done pulse. The result output then holds that value until the next block finishes.

The feedback form folds each nibble into the accumulator with an XOR tap pattern. This is the check used to protect topology and speed map blocks. A parameter can unroll several nibble steps into one clock to shorten the busy window.

Top module: `nibcrc_chk`

## Requirements
- R1: After synchronous active-high reset, in_ready is 1, crc_done is 0 and crc_out is 0.
- R2: A word accepted with in_first=1 is folded into an accumulator of zero, whatever value earlier blocks left behind.
- R3: Within a word, nibbles are folded in from bits 31:28 first down to bits 3:0 last, so 0x0000000F and 0xF0000000 give different results.
- R4: For each nibble n, s = acc[15:12] XOR n (4 bits), and the new acc = ((acc << 4) XOR (s << 12) XOR (s << 5) XOR s), truncated to 16 bits.
- R5: A word is accepted on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 for the next 8 cycles (default one nibble per clock) and returns to 1 after that.
- R6: crc_done is high for exactly one cycle. It rises on the 8th edge after the acceptance of a word with in_last=1, and crc_out carries the finished check value from that cycle on.
- R7: A word accepted with in_first=0 continues from the accumulator value left by the previous word.
- R8: A word accepted with in_last=0 produces no crc_done and leaves crc_out unchanged. in_valid asserted while in_ready is 0 is ignored: the word is not accepted and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | Input word, top nibble consumed first |
| in_first | input | 1 | Word starts a new block (accumulator cleared) |
| in_last | input | 1 | Word ends the block |
| crc_out | output | 16 | Last finished check value |
| crc_done | output | 1 | One-cycle pulse when a block finishes |

## Verification
The assertions assume that the inputs are at known levels from reset on. They also assume that a caller starts a new block only after the previous block's done pulse. They do not require the sender to hold in_valid or in_data while in_ready is low. The stimulus therefore deliberately drives unrelated data with in_valid high during the busy window, to show that such words are dropped. Every block the stimulus sends opens with a start-flagged word and closes with an end-flagged word. It waits for the done pulse before the next block, except where a word without a start flag is sent on purpose to continue the previous accumulator.

// File: rtl/nibcrc_pkg.sv
package nibcrc_pkg;
   localparam int CRC_W  = 16;
   localparam int NIB_W  = 4;
   localparam int WORD_W = 32;
   localparam int TAP_MID = 5;
   typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/nibcrc_step.sv
module nibcrc_step #(
   parameter int CRC_W   = 16,
   parameter int NIB_W   = 4,
   parameter int TAP_MID = 5
) (
   input  logic [CRC_W-1:0] acc_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic [CRC_W-1:0] acc_o
);
   localparam int LOW_W = CRC_W - NIB_W;

   logic [NIB_W-1:0] fb;

   always_comb begin
      fb    = acc_i[CRC_W-1 -: NIB_W] ^ nib_i;
      acc_o = {acc_i[LOW_W-1:0], {NIB_W{1'b0}}}
            ^ {fb, {LOW_W{1'b0}}}
            ^ (CRC_W'(fb) << TAP_MID)
            ^ CRC_W'(fb);
   end

   if (TAP_MID + NIB_W > CRC_W) begin : g_bad_tap
      $error("nibcrc_step: TAP_MID too large for CRC_W");
   end
endmodule

// File: rtl/nibcrc_chain.sv
module nibcrc_chain #(
   parameter int CRC_W   = 16,
   parameter int NIB_W   = 4,
   parameter int TAP_MID = 5,
   parameter int STEPS   = 1
) (
   input  logic [CRC_W-1:0]       acc_i,
   input  logic [STEPS*NIB_W-1:0] nibs_i,
   output logic [CRC_W-1:0]       acc_o
);
   logic [CRC_W-1:0] link [0:STEPS];

   assign link[0] = acc_i;

   for (genvar g = 0; g < STEPS; g++) begin : g_step
      nibcrc_step #(.CRC_W(CRC_W), .NIB_W(NIB_W), .TAP_MID(TAP_MID)) u_step (
         .acc_i (link[g]),
         .nib_i (nibs_i[STEPS*NIB_W-1-g*NIB_W -: NIB_W]),
         .acc_o (link[g+1])
      );
   end

   assign acc_o = link[STEPS];
endmodule

// File: rtl/nibcrc_shifter.sv
module nibcrc_shifter #(
   parameter int WORD_W = 32,
   parameter int NIB_W  = 4,
   parameter int STEPS  = 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load_i,
   input  logic [WORD_W-1:0]      word_i,
   input  logic                   last_i,
   output logic                   busy_o,
   output logic                   final_o,
   output logic                   last_o,
   output logic [STEPS*NIB_W-1:0] nibs_o
);
   localparam int SLICE_W = STEPS * NIB_W;
   localparam int CYCLES  = WORD_W / SLICE_W;
   localparam int CNT_W   = $clog2(CYCLES + 1);

   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg   <= '0;
         cnt    <= '0;
         busy_o <= 1'b0;
         last_o <= 1'b0;
      end else if (load_i) begin
         sreg   <= word_i;
         cnt    <= CNT_W'(CYCLES);
         busy_o <= 1'b1;
         last_o <= last_i;
      end else if (busy_o) begin
         sreg   <= sreg << SLICE_W;
         cnt    <= cnt - 1'b1;
         if (cnt == CNT_W'(1)) busy_o <= 1'b0;
      end
   end

   assign nibs_o  = sreg[WORD_W-1 -: SLICE_W];
   assign final_o = busy_o && (cnt == CNT_W'(1));

   AST_LOAD_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
      load_i |=> busy_o); // R5
   AST_BUSY_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> (cnt != '0)); // R5
   AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> !load_i); // R8

   if (WORD_W % SLICE_W != 0) begin : g_bad_steps
      $error("nibcrc_shifter: STEPS*NIB_W must divide WORD_W");
   end
endmodule

// File: rtl/nibcrc_chk.sv
module nibcrc_chk #(
   parameter int WORD_W  = nibcrc_pkg::WORD_W,
   parameter int CRC_W   = nibcrc_pkg::CRC_W,
   parameter int NIB_W   = nibcrc_pkg::NIB_W,
   parameter int TAP_MID = nibcrc_pkg::TAP_MID,
   parameter int STEPS   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_first,
   input  logic              in_last,
   output logic [CRC_W-1:0]  crc_out,
   output logic              crc_done
);
   localparam int SLICE_W = STEPS * NIB_W;

   logic               load;
   logic               busy;
   logic               final_step;
   logic               last_q;
   logic [SLICE_W-1:0] nibs;
   logic [CRC_W-1:0]   acc;
   logic [CRC_W-1:0]   acc_next;

   assign in_ready = !busy;
   assign load     = in_valid && in_ready;

   nibcrc_shifter #(.WORD_W(WORD_W), .NIB_W(NIB_W), .STEPS(STEPS)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load),
      .word_i  (in_data),
      .last_i  (in_last),
      .busy_o  (busy),
      .final_o (final_step),
      .last_o  (last_q),
      .nibs_o  (nibs)
   );

   nibcrc_chain #(.CRC_W(CRC_W), .NIB_W(NIB_W), .TAP_MID(TAP_MID), .STEPS(STEPS)) u_chain (
      .acc_i  (acc),
      .nibs_i (nibs),
      .acc_o  (acc_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc      <= '0;
         crc_out  <= '0;
         crc_done <= 1'b0;
      end else begin
         crc_done <= final_step && last_q;
         if (load && in_first) acc <= '0;
         else if (busy)        acc <= acc_next;
         if (final_step && last_q) crc_out <= acc_next;
      end
   end

   AST_FIRST_CLEARS_ACC: assert property (@(posedge clk) disable iff (rst)
      (load && in_first) |=> (acc == '0)); // R2
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
      load |=> !in_ready); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      crc_done |=> !crc_done); // R6
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
      crc_done |-> $past(busy)); // R6
   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !crc_done |-> $stable(crc_out)); // R8
   AST_ACC_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
      ($past(!busy) && $past(!load)) |-> $stable(acc)); // R7

   if (NIB_W > CRC_W || CRC_W < 2 * NIB_W) begin : g_bad_widths
      $error("nibcrc_chk: CRC_W must hold at least two nibbles");
   end
endmodule

// File: tb/nibcrc_chk_bench.sv
`timescale 1ns/1ps
module nibcrc_chk_bench;
   localparam int NIB_CYC = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_first = 1'b0;
   logic        in_last = 1'b0;
   logic [15:0] crc_out;
   logic        crc_done;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   nibcrc_chk u_nibcrc_chk (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .crc_out(crc_out), .crc_done(crc_done)
   );

   function automatic int fold_word(int acc, logic [31:0] w);
      int a = acc;
      for (int i = 7; i >= 0; i--) begin
         int n = int'((w >> (4 * i)) & 32'hF);
         int s = ((a >> 12) ^ n) & 15;
         a = ((a << 4) ^ (s << 12) ^ (s << 5) ^ s) & 16'hFFFF;
      end
      return a;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // cycle-by-cycle reference
   int m_cnt = 0, m_acc = 0, m_res = 0;
   bit m_last = 0, m_done = 0;

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_cnt = 0; m_acc = 0; m_res = 0; m_last = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0 && m_last) begin
               m_done = 1;
               m_res = m_acc;
            end
         end else if (in_valid) begin
            if (in_first) m_acc = 0;
            m_acc = fold_word(m_acc, in_data);
            m_cnt = NIB_CYC;
            m_last = in_last;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         check("R5 in_ready", int'(in_ready), int'(m_cnt == 0));
         check("R6 crc_done", int'(crc_done), int'(m_done));
         check("R4 crc_out", int'(crc_out), m_res);
      end
   end

   task automatic send(logic [31:0] w, bit first, bit last, bit junk);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = w; in_first = first; in_last = last;
      @(negedge clk);
      if (junk) begin
         in_data = 32'hA5C3_3C5A; in_first = 1'b1; in_last = 1'b1;
         repeat (5) @(negedge clk);
      end
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_data = '0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!crc_done && n < 40) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int ref_acc;
      int r_lo, r_hi;
      repeat (3) @(negedge clk);
      check("R1 ready after reset", int'(in_ready), 1);
      check("R1 done after reset", int'(crc_done), 0);
      check("R1 crc after reset", int'(crc_out), 0);
      rst = 1'b0;

      // R3: nibble order
      send(32'h0000_000F, 1, 1, 0); wait_done();
      r_lo = int'(crc_out);
      check("R3 low nibble word", r_lo, fold_word(0, 32'h0000_000F));
      send(32'hF000_0000, 1, 1, 0); wait_done();
      r_hi = int'(crc_out);
      check("R3 high nibble word", r_hi, fold_word(0, 32'hF000_0000));
      check("R3 order matters", int'(r_lo != r_hi), 1);

      // R7/R8: three-word block with junk offered while busy
      ref_acc = fold_word(0, 32'h1234_5678);
      send(32'h1234_5678, 1, 0, 1);
      repeat (8) @(negedge clk);
      check("R8 no done on non-last", int'(crc_done), 0);
      check("R8 crc unchanged", int'(crc_out), r_hi);
      ref_acc = fold_word(ref_acc, 32'h9ABC_DEF0);
      send(32'h9ABC_DEF0, 0, 0, 1);
      ref_acc = fold_word(ref_acc, 32'hDEAD_BEEF);
      send(32'hDEAD_BEEF, 0, 1, 0); wait_done();
      check("R7 multi-word result", int'(crc_out), ref_acc);
      @(negedge clk);
      check("R6 done single pulse", int'(crc_done), 0);

      // R2: restart clears previous accumulator
      send(32'hDEAD_BEEF, 1, 1, 0); wait_done();
      check("R2 restart from zero", int'(crc_out), fold_word(0, 32'hDEAD_BEEF));

      // R7: continue without first flag
      ref_acc = fold_word(fold_word(0, 32'hDEAD_BEEF), 32'hFFFF_FFFF);
      send(32'hFFFF_FFFF, 0, 1, 0); wait_done();
      check("R7 continue accumulator", int'(crc_out), ref_acc);

      // R4: edge patterns
      send(32'h0000_0000, 1, 1, 0); wait_done();
      check("R4 zero word", int'(crc_out), 0);
      send(32'h8000_0001, 1, 1, 0); wait_done();
      check("R4 sparse word", int'(crc_out), fold_word(0, 32'h8000_0001));

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule